// File: doc/BRIEF.md
# Narrow Write Burst Packer-Splitter

This block sits between an AXI write slave port that carries incrementing bursts of byte-wide beats and a word-oriented downstream bus. That downstream bus takes single 32-bit transfers and fixed-length word bursts, and each word carries byte enables. The block collects a whole upstream burst of 5 to 16 bytes and packs it into at most five 32-bit words, placing each byte in its address lane. It then issues those words as at most three downstream transactions, and it computes the address of each transaction from the address of the one before.

A partial word at either end of the packed sequence always becomes a single. The full words between the ends form one burst when there are two or more. One full word between the ends is sent as a single. After the final word of the final transaction is accepted, one OKAY write response goes back upstream. The AW length field sets the number of beats and WLAST is not used. The block assumes byte-sized INCR beats, and it assumes that only the first and last packed words have cleared strobes.

Top module: `nbw_pack_split`

## Requirements
- R1: Beat k of a burst that starts at address A goes to byte lane (A+k) mod 4 of packed word ((A mod 4)+k) div 4. Lane j occupies bits 8j+7:8j of m_data. Its strobe sets bit j of m_be.
- R2: The transaction pattern is chosen as follows. A first word whose byte enables are not 4'hF is sent alone. A last word that is not 4'hF is sent alone. Two or more full words between them form one burst, and a single full word between them is sent alone. This gives at most three transactions.
- R3: A burst drives m_burst=1, and m_len gives its word count (2 to 4). A single drives m_burst=0 and m_len=1, and all of its bytes are not necessarily enabled. m_tlast marks the final word of each transaction, and the words of a burst all carry m_be=4'hF.
- R4: The first transaction's address is the word-aligned start address plus the index of the lowest set bit in the first word's byte enables. If no bit is set, the index is 0.
- R5: A transaction that follows a single has the address of that single plus 4, with bits 1:0 cleared.
- R6: A transaction that follows a burst has the burst's start address plus 4 times the burst's word count.
- R7: s_bvalid rises, with s_bresp=2'b00 (OKAY), in the cycle after the last word of the last transaction is accepted. It is never asserted earlier.
- R8: s_wready is low while any packed word is waiting for downstream acceptance. s_awready is high only when no burst is in progress.
- R9: While m_valid is high and m_ready is low, m_valid, m_addr, m_burst, m_len, m_data and m_be stay unchanged.
- R10: Once s_bvalid is raised, it stays high until s_bready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Burst start byte address |
| s_awlen | input | LEN_W | Beats minus one |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 8 | Byte data |
| s_wstrb | input | 1 | Byte strobe |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code, always OKAY |
| m_valid | output | 1 | Downstream word valid |
| m_ready | input | 1 | Downstream word accepted |
| m_addr | output | ADDR_W | Current transaction address |
| m_burst | output | 1 | Current transaction is a word burst |
| m_len | output | 4 | Words in current transaction |
| m_data | output | 32 | Packed word |
| m_be | output | 4 | Byte enables of the word |
| m_tlast | output | 1 | Final word of current transaction |

## Verification
A packer lane counter that is off by one shows up on the very first downstream word as bytes in the wrong lanes or wrong byte enables. A wrong plan shows up at the first transaction boundary, where m_burst, m_len or m_tlast differ from the expected pattern. A fault in the address update stays hidden until the second transaction begins, and only then does m_addr differ. A response sequencer that is wrong shows up one cycle after the last acceptance, as an early, late or missing s_bvalid.

// File: rtl/nbw_pkg.sv
package nbw_pkg;
   localparam int unsigned LANES  = 4;
   localparam int unsigned LANE_W = 2;
   localparam int unsigned MAX_TX = 3;
   localparam int unsigned IDX_W  = 3;
   localparam int unsigned CNT_W  = IDX_W + 1;

   typedef struct packed {
      logic [IDX_W-1:0] first;
      logic [CNT_W-1:0] len;
      logic             burst;
   } tx_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_ISSUE = 2'd2,
      ST_RESP  = 2'd3
   } state_t;
endpackage

// File: rtl/nbw_packer.sv
module nbw_packer
   import nbw_pkg::*;
#(
   parameter int unsigned MAX_WORDS = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start,
   input  logic [LANE_W-1:0]                start_lane,
   input  logic                             beat_en,
   input  logic [7:0]                       beat_data,
   input  logic                             beat_strb,
   input  logic                             beat_last,
   output logic [MAX_WORDS-1:0][8*LANES-1:0] word_data,
   output logic [MAX_WORDS-1:0][LANES-1:0]   word_be,
   output logic [CNT_W-1:0]                  word_cnt
);
   logic [LANE_W-1:0]  lane_q;
   logic [8*LANES-1:0] acc_data, merged_data;
   logic [LANES-1:0]   acc_be, merged_be;
   logic [CNT_W-1:0]   wptr_q;
   logic               close_word;

   always_comb begin
      merged_data = acc_data;
      merged_be   = acc_be;
      merged_data[8*lane_q +: 8] = beat_data;
      merged_be[lane_q]          = beat_strb;
      close_word = beat_en && ((lane_q == LANE_W'(LANES-1)) || beat_last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_q   <= '0;
         acc_data <= '0;
         acc_be   <= '0;
         wptr_q   <= '0;
      end else if (start) begin
         lane_q   <= start_lane;
         acc_data <= '0;
         acc_be   <= '0;
         wptr_q   <= '0;
      end else if (beat_en) begin
         lane_q <= lane_q + 1'b1;
         if (close_word) begin
            acc_data <= '0;
            acc_be   <= '0;
            wptr_q   <= wptr_q + 1'b1;
         end else begin
            acc_data <= merged_data;
            acc_be   <= merged_be;
         end
      end
   end

   for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_data[g] <= '0;
            word_be[g]   <= '0;
         end else if (close_word && (wptr_q == CNT_W'(g))) begin
            word_data[g] <= merged_data;
            word_be[g]   <= merged_be;
         end
      end
   end

   assign word_cnt = wptr_q;
endmodule

// File: rtl/nbw_planner.sv
module nbw_planner
   import nbw_pkg::*;
#(
   parameter int unsigned MAX_WORDS = 5
) (
   input  logic [MAX_WORDS-1:0][LANES-1:0] word_be,
   input  logic [CNT_W-1:0]                word_cnt,
   output tx_t  [MAX_TX-1:0]               txs,
   output logic [1:0]                      tx_cnt
);
   logic [IDX_W-1:0] last_idx;
   logic             lead, trail;
   logic [CNT_W-1:0] mid;
   logic [1:0]       k;

   always_comb begin
      last_idx = (word_cnt == '0) ? '0 : IDX_W'(word_cnt - 1'b1);
      if (word_cnt <= CNT_W'(1)) begin
         lead  = 1'b1;
         trail = 1'b0;
      end else begin
         lead  = (word_be[0] != '1);
         trail = (word_be[last_idx] != '1);
      end
      mid = word_cnt - CNT_W'(lead) - CNT_W'(trail);

      txs = '0;
      k   = '0;
      if (lead) begin
         txs[k] = '{first: '0, len: CNT_W'(1), burst: 1'b0};
         k = k + 1'b1;
      end
      if (mid >= CNT_W'(2)) begin
         txs[k] = '{first: IDX_W'(lead), len: mid, burst: 1'b1};
         k = k + 1'b1;
      end else if (mid == CNT_W'(1)) begin
         txs[k] = '{first: IDX_W'(lead), len: CNT_W'(1), burst: 1'b0};
         k = k + 1'b1;
      end
      if (trail) begin
         txs[k] = '{first: last_idx, len: CNT_W'(1), burst: 1'b0};
         k = k + 1'b1;
      end
      tx_cnt = k;
   end
endmodule

// File: rtl/nbw_issuer.sv
module nbw_issuer
   import nbw_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned MAX_WORDS = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             active,
   input  logic [ADDR_W-1:0]                base_addr,
   input  logic [MAX_WORDS-1:0][8*LANES-1:0] word_data,
   input  logic [MAX_WORDS-1:0][LANES-1:0]   word_be,
   input  tx_t  [MAX_TX-1:0]                 txs,
   input  logic [1:0]                        tx_cnt,
   input  logic                              m_ready,
   output logic                              m_valid,
   output logic [ADDR_W-1:0]                 m_addr,
   output logic                              m_burst,
   output logic [CNT_W-1:0]                  m_len,
   output logic [8*LANES-1:0]                m_data,
   output logic [LANES-1:0]                  m_be,
   output logic                              m_tlast,
   output logic                              all_done
);
   logic [1:0]        tidx_q;
   logic [IDX_W-1:0]  wcnt_q;
   logic [ADDR_W-1:0] addr_q, next_addr;
   logic [LANE_W-1:0] first_off;
   logic [IDX_W-1:0]  sel;
   tx_t               cur;
   logic              accept;

   always_comb begin
      first_off = '0;
      for (int i = LANES-1; i >= 0; i--) begin
         if (word_be[0][i]) first_off = LANE_W'(i);
      end
   end

   always_comb begin
      cur     = txs[tidx_q];
      sel     = cur.first + wcnt_q;
      m_valid = active;
      m_addr  = (tidx_q == '0) ? {base_addr[ADDR_W-1:LANE_W], first_off} : addr_q;
      m_burst = cur.burst;
      m_len   = cur.len;
      m_data  = word_data[sel];
      m_be    = word_be[sel];
      m_tlast = ({1'b0, wcnt_q} == (cur.len - 1'b1));
      accept  = active && m_ready;
      all_done = accept && m_tlast && (tidx_q == (tx_cnt - 1'b1));
      if (cur.burst)
         next_addr = m_addr + ADDR_W'({cur.len, {LANE_W{1'b0}}});
      else
         next_addr = {m_addr[ADDR_W-1:LANE_W] + 1'b1, {LANE_W{1'b0}}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         tidx_q <= '0;
         wcnt_q <= '0;
         addr_q <= '0;
      end else if (accept) begin
         if (m_tlast) begin
            wcnt_q <= '0;
            tidx_q <= tidx_q + 1'b1;
            addr_q <= next_addr;
         end else begin
            wcnt_q <= wcnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/nbw_pack_split.sv
module nbw_pack_split
   import nbw_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LEN_W     = 8,
   parameter int unsigned MAX_BEATS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic [LEN_W-1:0]  s_awlen,
   input  logic              s_wvalid,
   output logic              s_wready,
   input  logic [7:0]        s_wdata,
   input  logic              s_wstrb,
   output logic              s_bvalid,
   input  logic              s_bready,
   output logic [1:0]        s_bresp,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [ADDR_W-1:0] m_addr,
   output logic              m_burst,
   output logic [3:0]        m_len,
   output logic [31:0]       m_data,
   output logic [3:0]        m_be,
   output logic              m_tlast
);
   localparam int unsigned MAX_WORDS = (MAX_BEATS + 2*LANES - 2) / LANES;

   if (MAX_BEATS < 5 || MAX_WORDS > (1 << IDX_W) - 1) begin : g_bad_beats
      $error("nbw_pack_split: MAX_BEATS out of supported range");
   end
   if (ADDR_W < 4 || (1 << LEN_W) < MAX_BEATS) begin : g_bad_width
      $error("nbw_pack_split: address or length width too small");
   end
   if (CNT_W != 4) begin : g_bad_cnt
      $error("nbw_pack_split: m_len width mismatch");
   end

   state_t            state_q, state_d;
   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  left_q;
   logic              aw_hs, w_hs, w_last, done;

   logic [MAX_WORDS-1:0][8*LANES-1:0] word_data;
   logic [MAX_WORDS-1:0][LANES-1:0]   word_be;
   logic [CNT_W-1:0]                  word_cnt;
   tx_t  [MAX_TX-1:0]                 txs;
   logic [1:0]                        tx_cnt;

   assign s_awready = (state_q == ST_IDLE);
   assign s_wready  = (state_q == ST_FILL);
   assign s_bvalid  = (state_q == ST_RESP);
   assign s_bresp   = 2'b00;
   assign aw_hs     = s_awready && s_awvalid;
   assign w_hs      = s_wready && s_wvalid;
   assign w_last    = (left_q == '0);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (aw_hs) state_d = ST_FILL;
         ST_FILL:  if (w_hs && w_last) state_d = ST_ISSUE;
         ST_ISSUE: if (done) state_d = ST_RESP;
         ST_RESP:  if (s_bready) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         left_q  <= '0;
      end else begin
         state_q <= state_d;
         if (aw_hs) begin
            base_q <= {s_awaddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            left_q <= s_awlen;
         end else if (w_hs) begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   nbw_packer #(.MAX_WORDS(MAX_WORDS)) u_packer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (aw_hs),
      .start_lane (s_awaddr[LANE_W-1:0]),
      .beat_en    (w_hs),
      .beat_data  (s_wdata),
      .beat_strb  (s_wstrb),
      .beat_last  (w_last),
      .word_data  (word_data),
      .word_be    (word_be),
      .word_cnt   (word_cnt)
   );

   nbw_planner #(.MAX_WORDS(MAX_WORDS)) u_planner (
      .word_be  (word_be),
      .word_cnt (word_cnt),
      .txs      (txs),
      .tx_cnt   (tx_cnt)
   );

   nbw_issuer #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) u_issuer (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (state_q == ST_ISSUE),
      .base_addr (base_q),
      .word_data (word_data),
      .word_be   (word_be),
      .txs       (txs),
      .tx_cnt    (tx_cnt),
      .m_ready   (m_ready),
      .m_valid   (m_valid),
      .m_addr    (m_addr),
      .m_burst   (m_burst),
      .m_len     (m_len),
      .m_data    (m_data),
      .m_be      (m_be),
      .m_tlast   (m_tlast),
      .all_done  (done)
   );
endmodule

// File: rtl/nbw_pack_split_chk.sv
module nbw_pack_split_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_awready,
   input logic              s_wready,
   input logic              s_bvalid,
   input logic              s_bready,
   input logic [1:0]        s_bresp,
   input logic              m_valid,
   input logic              m_ready,
   input logic [ADDR_W-1:0] m_addr,
   input logic              m_burst,
   input logic [3:0]        m_len,
   input logic [31:0]       m_data,
   input logic [3:0]        m_be,
   input logic              m_tlast
);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_data)
                              && $stable(m_be) && $stable(m_len) && $stable(m_burst));

   assert_bhold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid && !s_bready |=> s_bvalid);

   assert_okay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> s_bresp == 2'b00);

   assert_bafter_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_bvalid) |-> $past(m_valid && m_ready && m_tlast));

   assert_wblock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> !s_wready);

   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      s_awready |-> !m_valid && !s_bvalid && !s_wready);

   assert_burst_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && m_burst |-> m_len >= 4'd2 && m_be == 4'hF && m_addr[1:0] == 2'b00);

   assert_single_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_burst |-> m_len == 4'd1 && m_tlast);
endmodule

bind nbw_pack_split nbw_pack_split_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_awready (s_awready),
   .s_wready  (s_wready),
   .s_bvalid  (s_bvalid),
   .s_bready  (s_bready),
   .s_bresp   (s_bresp),
   .m_valid   (m_valid),
   .m_ready   (m_ready),
   .m_addr    (m_addr),
   .m_burst   (m_burst),
   .m_len     (m_len),
   .m_data    (m_data),
   .m_be      (m_be),
   .m_tlast   (m_tlast)
);

// File: tb/nbw_pack_split_tb.sv
`timescale 1ns/1ps
module nbw_pack_split_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_awvalid = 1'b0;
   logic [31:0] s_awaddr = '0;
   logic [7:0]  s_awlen = '0;
   logic        s_wvalid = 1'b0;
   logic [7:0]  s_wdata = '0;
   logic        s_wstrb = 1'b0;
   logic        s_bready = 1'b0;
   logic        m_ready = 1'b0;
   logic        s_awready, s_wready, s_bvalid;
   logic [1:0]  s_bresp;
   logic        m_valid, m_burst, m_tlast;
   logic [31:0] m_addr, m_data;
   logic [3:0]  m_len, m_be;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   nbw_pack_split u_dut (
      .clk(clk), .rst_n(rst_n),
      .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awlen(s_awlen),
      .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
      .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
      .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_burst(m_burst),
      .m_len(m_len), .m_data(m_data), .m_be(m_be), .m_tlast(m_tlast)
   );

   // expected downstream words
   logic [31:0] e_addr [5];
   logic        e_burst[5];
   logic [3:0]  e_len  [5];
   logic [31:0] e_data [5];
   logic [3:0]  e_be   [5];
   logic        e_tlast[5];
   string       e_areq [5];
   int          e_n;
   logic [7:0]  bdata[16];
   logic        bstrb[16];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] low_bit(input logic [3:0] be);
      for (int i = 0; i < 4; i++) if (be[i]) return 2'(i);
      return 2'd0;
   endfunction

   // model: packing (R1), split (R2), addresses (R4, R5, R6)
   task automatic build_expect(input logic [31:0] addr, input int len);
      logic [31:0] w_data[5];
      logic [3:0]  w_be[5];
      int n, lead, trail, mid, nt;
      int t_first[3], t_cnt[3];
      bit t_burst[3];
      logic [31:0] a;
      for (int i = 0; i < 5; i++) begin w_data[i] = '0; w_be[i] = '0; end
      for (int k = 0; k < len; k++) begin
         int w, l;
         w = (int'(addr[1:0]) + k) / 4;
         l = (int'(addr[1:0]) + k) % 4;
         w_data[w][8*l +: 8] = bdata[k];
         w_be[w][l] = bstrb[k];
      end
      n = (int'(addr[1:0]) + len - 1) / 4 + 1;
      lead  = (w_be[0] != 4'hF) ? 1 : 0;
      trail = (w_be[n-1] != 4'hF) ? 1 : 0;
      mid = n - lead - trail;
      nt = 0;
      if (lead == 1) begin t_first[nt] = 0; t_cnt[nt] = 1; t_burst[nt] = 0; nt++; end
      if (mid >= 2) begin t_first[nt] = lead; t_cnt[nt] = mid; t_burst[nt] = 1; nt++; end
      else if (mid == 1) begin t_first[nt] = lead; t_cnt[nt] = 1; t_burst[nt] = 0; nt++; end
      if (trail == 1) begin t_first[nt] = n-1; t_cnt[nt] = 1; t_burst[nt] = 0; nt++; end
      a = {addr[31:2], 2'b00} + 32'(low_bit(w_be[0]));
      e_n = 0;
      for (int t = 0; t < nt; t++) begin
         for (int j = 0; j < t_cnt[t]; j++) begin
            e_addr[e_n]  = a;
            e_burst[e_n] = t_burst[t];
            e_len[e_n]   = 4'(t_cnt[t]);
            e_data[e_n]  = w_data[t_first[t] + j];
            e_be[e_n]    = w_be[t_first[t] + j];
            e_tlast[e_n] = (j == t_cnt[t] - 1);
            e_areq[e_n]  = (t == 0) ? "R4" : (t_burst[t-1] ? "R6" : "R5");
            e_n++;
         end
         if (t_burst[t]) a = a + 32'(4 * t_cnt[t]);
         else            a = {a[31:2] + 30'd1, 2'b00};
      end
   endtask

   task automatic run_burst(input logic [31:0] addr, input int len, input bit all_on);
      int lastw;
      bit stall;
      logic [31:0] s_a, s_d;
      logic [3:0]  s_b, s_l;
      logic        s_bu;
      int idx, dly;
      lastw = (int'(addr[1:0]) + len - 1) / 4;
      for (int k = 0; k < len; k++) begin
         int w;
         w = (int'(addr[1:0]) + k) / 4;
         bdata[k] = 8'($urandom);
         if (all_on || (w != 0 && w != lastw)) bstrb[k] = 1'b1;
         else bstrb[k] = ($urandom % 3) != 0;
      end
      build_expect(addr, len);
      // address phase
      @(negedge clk);
      s_awvalid = 1'b1; s_awaddr = addr; s_awlen = 8'(len - 1);
      while (!s_awready) @(negedge clk);
      @(posedge clk); #1 s_awvalid = 1'b0;
      // data phase
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         if (($urandom % 4) == 0) @(negedge clk);
         s_wvalid = 1'b1; s_wdata = bdata[k]; s_wstrb = bstrb[k];
         while (!s_wready) @(negedge clk);
         @(posedge clk); #1 s_wvalid = 1'b0;
      end
      // downstream collection
      idx = 0; stall = 0;
      s_a = '0; s_d = '0; s_b = '0; s_l = '0; s_bu = 1'b0;
      while (idx < e_n) begin
         @(negedge clk);
         m_ready = ($urandom % 4) != 0;
         chk(s_bvalid == 1'b0, "R7 early response", 64'(s_bvalid), 64'(0));
         if (m_valid) begin
            chk(s_wready == 1'b0, "R8 wready while word pending", 64'(s_wready), 64'(0));
            if (stall) begin
               chk({m_addr, m_data, m_be, m_len, m_burst} == {s_a, s_d, s_b, s_l, s_bu},
                   "R9 stall stability", 64'(m_data), 64'(s_d));
            end
            if (m_ready) begin
               chk(m_data == e_data[idx], "R1 data", 64'(m_data), 64'(e_data[idx]));
               chk(m_be == e_be[idx], "R1 byte enables", 64'(m_be), 64'(e_be[idx]));
               chk(m_burst == e_burst[idx], "R2 burst select", 64'(m_burst), 64'(e_burst[idx]));
               chk(m_len == e_len[idx], "R3 length", 64'(m_len), 64'(e_len[idx]));
               chk(m_tlast == e_tlast[idx], "R3 tlast", 64'(m_tlast), 64'(e_tlast[idx]));
               chk(m_addr == e_addr[idx], e_areq[idx], 64'(m_addr), 64'(e_addr[idx]));
               idx++;
               stall = 0;
            end else begin
               stall = 1;
               s_a = m_addr; s_d = m_data; s_b = m_be; s_l = m_len; s_bu = m_burst;
            end
         end
      end
      // response phase
      @(negedge clk);
      m_ready = 1'b0;
      chk(m_valid == 1'b0, "R2 extra downstream word", 64'(m_valid), 64'(0));
      chk(s_bvalid == 1'b1 && s_bresp == 2'b00, "R7 response after last ack",
          64'({s_bvalid, s_bresp}), 64'(3'b100));
      dly = $urandom % 3;
      for (int d = 0; d < dly; d++) begin
         @(negedge clk);
         chk(s_bvalid == 1'b1, "R10 response held", 64'(s_bvalid), 64'(1));
      end
      s_bready = 1'b1;
      @(posedge clk); #1 s_bready = 1'b0;
      @(negedge clk);
      chk(s_bvalid == 1'b0 && s_awready == 1'b1, "R8 idle after response",
          64'({s_bvalid, s_awready}), 64'(2'b01));
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(s_awready == 1'b1 && s_wready == 1'b0 && m_valid == 1'b0 && s_bvalid == 1'b0,
          "R8 reset state", 64'({s_awready, s_wready, m_valid, s_bvalid}), 64'(4'b1000));
      // directed patterns
      run_burst(32'h1000, 16, 1);  // R2: B(4)
      run_burst(32'h2001, 16, 1);  // R2: S,B(3),S
      run_burst(32'h3001, 8, 1);   // R2: S,S,S
      run_burst(32'h4003, 5, 1);   // R2: S,S
      run_burst(32'h5001, 11, 1);  // R2: S,B(2)
      run_burst(32'h6000, 9, 1);   // R2: B(2),S
      run_burst(32'h7000, 8, 1);   // R2: B(2)
      run_burst(32'h8000, 5, 1);   // R2: S,S (full then partial)
      bdata[0] = 8'h00;
      run_burst(32'h9002, 6, 1);   // R4: offset 2
      // random mix
      for (int r = 0; r < 400; r++) begin
         run_burst($urandom & 32'hFFFF_FFF0 | ($urandom % 4), 5 + ($urandom % 12), ($urandom % 4) == 0);
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end
endmodule